// File: doc/BRIEF.md
# Interrupt Request Latch with Delivery Status

This block holds the pending-request bits for sixteen interrupt lines split across two cascaded eight-input controllers. A requester presents a line number and a level together with an update strobe; the block updates that line's pending bit according to its trigger mode, edge or level, and reports how the request fared. The report is one of three codes: the line is masked, the request was lost because it merged with one already pending, or the request was taken.

The status appears one cycle after the strobe, qualified by a single-cycle valid pulse. When a second interrupt controller sees the same request and supplies its own status, the block returns the better of the two outcomes. A device model or a rate-compensating timer can use this to tell a delivered tick from a lost one. Priority resolution, acknowledge cycles and vector generation are handled elsewhere.

Top module: `irq_coalesce_latch`

## Requirements
- R1: While rst_ni is low, pending_o is all zeros, status_vld_o is 0 and status_o is 2'b00.
- R2: Bit 3 of line_i selects the controller (0 for lines 0-7, 1 for lines 8-15) and bits 2:0 select the pin; the update acts on pending_o bit number line_i.
- R3: For an edge-mode line (trig_mode_i bit = 0), an update with level_i = 1 whose stored previous level is 0 sets the pending bit; if that bit was 0 beforehand the raw status is accepted (2'b10).
- R4: For an edge-mode line, a rising edge (level_i = 1, stored previous level 0) that finds the pending bit already 1 leaves it at 1 and gives raw status coalesced (2'b01).
- R5: For an edge-mode line, level_i = 0 only clears the stored previous level and leaves the pending bit unchanged; level_i = 1 with stored previous level 1 also leaves it unchanged; both give raw status accepted.
- R6: For a level-mode line (trig_mode_i bit = 1), the pending bit takes the value of level_i and the raw status is accepted. In both modes every update stores level_i as the line's previous level.
- R7: If mask_i bit line_i is 1 at the update, the local status is masked (2'b00) regardless of the raw status; the pending bit still updates as in R3-R6.
- R8: status_vld_o is 1 exactly in the cycle after each cycle with upd_i = 1, and status_o then carries the result; status_o never shows 2'b11 while valid and holds its last value otherwise.
- R9: When alt_vld_i is 1 at the update, status_o is the higher of the local status and alt_status_i under the order masked < coalesced < accepted, with an alt_status_i of 2'b11 ranked as accepted; when alt_vld_i is 0, alt_status_i has no effect.
- R10: An update changes no pending bit other than the addressed line's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Update strobe for one request |
| line_i | input | 4 | Line number of the update |
| level_i | input | 1 | Input level applied to the line |
| trig_mode_i | input | 16 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_i | input | 16 | Per-line mask, 1 = masked |
| alt_vld_i | input | 1 | Second controller supplies a status this update |
| alt_status_i | input | 2 | Second controller's status code |
| pending_o | output | 16 | Pending-request bits, bit n = line n |
| status_vld_o | output | 1 | Status valid pulse |
| status_o | output | 2 | Status: 00 masked, 01 coalesced, 10 accepted |

## Verification
On every cycle the assertions check that the valid pulse follows each strobe and nothing else, that a masked update without merge reports masked, that an accepted peer forces accepted, that untouched lines keep their pending bits, and that edge and level updates move the addressed bit the right way. Whether a rising edge is reported coalesced or accepted depends on the stored previous level and pending history of that line, so only the bench's long mixed sweep, checked against its own model of every line, shows the coalescing results, the controller split and the merge ranking over all code pairs.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned CTRL_N = 2;
  localparam int unsigned PINS_N = 8;

  typedef enum logic [1:0] {
    ST_MASKED    = 2'b00,
    ST_COALESCED = 2'b01,
    ST_ACCEPTED  = 2'b10
  } irq_status_e;

  // rank a foreign code; the unused code counts as accepted
  function automatic irq_status_e clamp_status(logic [1:0] code);
    return (code == 2'b11) ? ST_ACCEPTED : irq_status_e'(code);
  endfunction
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_latch_pkg::*;
#(
  parameter int unsigned PINS  = PINS_N,
  localparam int unsigned PIN_W = $clog2(PINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [PIN_W-1:0] pin_i,
  input  logic             level_i,
  input  logic [PINS-1:0]  mode_i,
  input  logic [PINS-1:0]  mask_i,
  output logic [PINS-1:0]  pending_o,
  output irq_status_e      status_o
);
  logic [PINS-1:0] pend_q, pend_d;
  logic [PINS-1:0] prev_q, prev_d;
  irq_status_e     raw;

  always_comb begin
    pend_d = pend_q;
    prev_d = prev_q;
    raw    = ST_ACCEPTED;
    if (sel_i) begin
      prev_d[pin_i] = level_i;
      if (mode_i[pin_i]) begin
        pend_d[pin_i] = level_i;
      end else if (level_i && !prev_q[pin_i]) begin
        if (pend_q[pin_i]) raw = ST_COALESCED;
        pend_d[pin_i] = 1'b1;
      end
    end
  end

  assign status_o  = mask_i[pin_i] ? ST_MASKED : raw;
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  AST_UNSEL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(pend_q)); // R10
  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !mode_i[pin_i] && level_i |=> pend_q[$past(pin_i)]); // R3
  AST_FALL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !mode_i[pin_i] && !level_i |=> pend_q[$past(pin_i)] == $past(pend_q[pin_i])); // R5
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && mode_i[pin_i] |=> pend_q[$past(pin_i)] == $past(level_i)); // R6
endmodule

// File: rtl/irq_status_merge.sv
module irq_status_merge
  import irq_latch_pkg::*;
(
  input  irq_status_e local_i,
  input  logic        alt_vld_i,
  input  logic [1:0]  alt_status_i,
  output irq_status_e merged_o
);
  irq_status_e alt;
  assign alt      = clamp_status(alt_status_i);
  assign merged_o = (alt_vld_i && (alt > local_i)) ? alt : local_i;

  always_comb begin
    AST_MERGE_NOT_LOWER: assert (merged_o >= local_i); // R9
  end
endmodule

// File: rtl/irq_coalesce_latch.sv
module irq_coalesce_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned CTRLS  = CTRL_N,
  parameter int unsigned PINS   = PINS_N,
  localparam int unsigned LINES  = CTRLS * PINS,
  localparam int unsigned PIN_W  = $clog2(PINS),
  localparam int unsigned LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              level_i,
  input  logic [LINES-1:0]  trig_mode_i,
  input  logic [LINES-1:0]  mask_i,
  input  logic              alt_vld_i,
  input  logic [1:0]        alt_status_i,
  output logic [LINES-1:0]  pending_o,
  output logic              status_vld_o,
  output logic [1:0]        status_o
);
  localparam int unsigned CTRL_W = (CTRLS > 1) ? LINE_W - PIN_W : 1;

  logic [PIN_W-1:0]  pin;
  logic [CTRL_W-1:0] ctrl;
  irq_status_e       bank_st [CTRLS];
  irq_status_e       local_st, merged_st;
  logic [1:0]        status_q;
  logic              vld_q;

  assign pin = line_i[PIN_W-1:0];
  if (CTRLS > 1) begin : g_ctrl_sel
    assign ctrl = line_i[LINE_W-1:PIN_W];
  end else begin : g_ctrl_one
    assign ctrl = '0;
  end

  for (genvar c = 0; c < CTRLS; c++) begin : g_bank
    irq_line_bank #(.PINS(PINS)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (upd_i && (ctrl == CTRL_W'(c))),
      .pin_i     (pin),
      .level_i   (level_i),
      .mode_i    (trig_mode_i[c*PINS +: PINS]),
      .mask_i    (mask_i[c*PINS +: PINS]),
      .pending_o (pending_o[c*PINS +: PINS]),
      .status_o  (bank_st[c])
    );
  end

  assign local_st = bank_st[ctrl];

  irq_status_merge i_merge (
    .local_i      (local_st),
    .alt_vld_i    (alt_vld_i),
    .alt_status_i (alt_status_i),
    .merged_o     (merged_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      status_q <= ST_MASKED;
    end else begin
      vld_q <= upd_i;
      if (upd_i) status_q <= merged_st;
    end
  end

  assign status_vld_o = vld_q;
  assign status_o     = status_q;

  AST_VLD_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> $past(upd_i)); // R8
  AST_UPD_GIVES_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> status_vld_o); // R8
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> status_o != 2'b11); // R8
  AST_MASK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && mask_i[line_i] && !alt_vld_i |=> status_o == ST_MASKED); // R7
  AST_PEER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && alt_vld_i && alt_status_i[1] |=> status_o == ST_ACCEPTED); // R9
endmodule

// File: tb/test_irq_coalesce_latch.sv
module test_irq_coalesce_latch;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd = 1'b0;
  logic [3:0]  line = '0;
  logic        level = 1'b0;
  logic [15:0] mode = '0;
  logic [15:0] mask = '0;
  logic        alt_vld = 1'b0;
  logic [1:0]  alt_st = '0;
  logic [15:0] pending;
  logic        vld;
  logic [1:0]  st;

  int total = 0;
  int bad = 0;
  logic [15:0] m_pend = '0;
  logic [15:0] m_prev = '0;
  logic [1:0]  m_st = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  irq_coalesce_latch i_irq_coalesce_latch (
    .clk_i(clk), .rst_ni(rst_ni), .upd_i(upd), .line_i(line), .level_i(level),
    .trig_mode_i(mode), .mask_i(mask), .alt_vld_i(alt_vld), .alt_status_i(alt_st),
    .pending_o(pending), .status_vld_o(vld), .status_o(st)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] s, logic e_mode, logic e_mask, logic e_alt);
    if (e_alt) return "R9";
    if (e_mask) return "R7";
    if (s == 2'b01) return "R4";
    if (e_mode) return "R6";
    return "R3";
  endfunction

  // model from the requirements, then one update and its checks
  task automatic apply(input logic [3:0] l, input logic lv, input logic av, input logic [1:0] as);
    logic [1:0] s;
    logic [1:0] a;
    s = 2'b10;
    if (mode[l]) m_pend[l] = lv;
    else if (lv && !m_prev[l]) begin
      if (m_pend[l]) s = 2'b01;
      m_pend[l] = 1'b1;
    end
    m_prev[l] = lv;
    if (mask[l]) s = 2'b00;
    a = (as == 2'b11) ? 2'b10 : as;
    if (av && a > s) s = a;
    m_st = s;
    @(negedge clk);
    line = l; level = lv; alt_vld = av; alt_st = as; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    check("R8 valid", 32'(vld), 32'd1);
    check(tag_of(s, mode[l], mask[l], av), 32'(st), 32'(s));
    check("R2 R10 pending", 32'(pending), 32'(m_pend));
  endtask

  initial begin
    #200000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pending", 32'(pending), 32'd0);
    check("R1 valid", 32'(vld), 32'd0);
    check("R1 status", 32'(st), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8 idle", 32'(vld), 32'd0);

    // R3 / R4 / R5 on line 11 (controller 1, pin 3)
    apply(4'd11, 1'b1, 1'b0, 2'b00);
    check("R3 accepted", 32'(st), 32'd2);
    check("R2 bit11", 32'(pending), 32'h0800);
    apply(4'd11, 1'b1, 1'b0, 2'b00);
    check("R5 no edge", 32'(st), 32'd2);
    apply(4'd11, 1'b0, 1'b0, 2'b00);
    check("R5 fall keeps", 32'(pending[11]), 32'd1);
    apply(4'd11, 1'b1, 1'b0, 2'b00);
    check("R4 coalesced", 32'(st), 32'd1);
    @(negedge clk);
    check("R8 one pulse", 32'(vld), 32'd0);
    check("R8 hold", 32'(st), 32'd1);
    // R7 mask over coalesce, R9 merge
    mask[3] = 1'b1;
    apply(4'd3, 1'b1, 1'b0, 2'b00);
    apply(4'd3, 1'b0, 1'b0, 2'b00);
    apply(4'd3, 1'b1, 1'b1, 2'b01);
    check("R9 peer coalesced beats masked", 32'(st), 32'd1);
    apply(4'd3, 1'b1, 1'b1, 2'b11);
    check("R9 code 3 as accepted", 32'(st), 32'd2);
    apply(4'd3, 1'b0, 1'b0, 2'b10);
    check("R9 alt ignored", 32'(st), 32'd0);
    // R6 level mode clears
    mode[3] = 1'b1;
    apply(4'd3, 1'b0, 1'b0, 2'b00);
    check("R6 level clear", 32'(pending[3]), 32'd0);
    mask = '0;

    // sweep: mixed lines, levels, modes, masks, merges
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 64 == 0) begin
        mode = lfsr ^ 16'h5A3C;
        mask = {lfsr[7:0], lfsr[15:8]} & 16'h9249;
      end
      apply(lfsr[3:0] ^ 4'(i), lfsr[5] ^ lfsr[9], (lfsr[11:8] == 4'd0), lfsr[13:12]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule